// File: doc/BRIEF.md
# Byte-command SPI master with register interface

This block is an SPI master that moves exactly one byte per software command. A processor reaches it through a small 32-bit register window. Through that window it sets the serial clock rate, the idle level of the clock, the clock edge that launches outgoing bits, the clock edge that samples incoming bits, and the bit order. It then starts either a one-byte write or a one-byte read. A transfer never sends and receives useful data at the same time.

The chip-select pin is not sequenced by the block. It follows a level bit that software writes, so a multi-byte frame is built by lowering chip select, issuing byte commands one after another while polling the busy flag, and raising chip select again. The serial clock is the system clock divided by a power of two. The launch edge and the sample edge are each named as an absolute rising or falling edge, independently of the idle level. This lets all four usual clock modes be expressed, as well as the two non-standard pairings in which both selects name the same edge.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the status word reads 0, the configuration word reads 0, the control word reads 1, the data word reads 0, cs_o is high and sck_o is low.
- R2: The word at byte offset 0x10 keeps bits [2:0] (prescale P), 4 (launch on falling edge), 5 (sample on falling edge), 6 (clock idle high) and 8 (MSB first), and reads every other bit as 0. The control word at 0x14 reads back only bit 0, and its bits 1 and 2 always read 0. The data word at 0x20 keeps and returns only its low 8 bits. Every other offset in the window reads 0 and ignores writes.
- R3: Status bit 0 (busy) at offset 0x00 rises in the cycle after a start is accepted and stays high for exactly 16·2^min(P,6) system clock cycles.
- R4: sck_o rests at the level of configuration bit 6 whenever no transfer is running, and makes exactly 16 transitions per byte, spaced 2^min(P,6) cycles apart.
- R5: With configuration bit 4 set, mosi_o changes only on falling sck_o edges; with it clear, only on rising edges. The first bit is on mosi_o from the cycle busy rises, and mosi_o never changes while sck_o holds its level.
- R6: With configuration bit 5 set, miso_i is sampled on the falling sck_o edges; with it clear, on the rising edges. Eight samples are taken per byte.
- R7: With configuration bit 8 set, bit 7 is sent first and the first received bit lands in bit 7. With it clear, bit 0 goes first in both directions.
- R8: Writing control bit 2 starts a write of data bits [7:0]. The data word is left unchanged by the write, and whatever arrives on miso_i is dropped.
- R9: Writing control bit 1 (with bit 2 clear) starts a read. At its end the received byte is in data bits [7:0], with the upper bits 0.
- R10: Every write to the control word sets cs_o to written bit 0 from the next cycle on, including writes made while busy.
- R11: While busy, start bits and writes to the configuration and data words are ignored. The running byte, its length and the stored configuration and data stay as they were.
- R12: A control write with both bits 1 and 2 set starts a write.
- R13: A prescale value of 7 gives the same clock rate as 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip-select level from the control word |

## Verification
The bench sweeps every pairing of idle level, launch edge and sample edge in both bit orders, for reads and writes at the two fastest rates. It also sweeps every prescale code, including the out-of-range 7. A small slave model in the bench shifts on the edges opposite to the master's, so the following faults each leave a wrong byte at one end:
- a master that launches or samples on the wrong edge;
- a master that advances its first bit one edge early;
- a master that reverses the bit order in only one direction.

Busy length and the count of clock transitions are measured, which exposes an off-by-one divider, a lost or extra edge, or a prescale 7 that divides by 256. A transfer is also disturbed mid-flight by data, configuration and start writes. Only the chip-select bit may take effect; a design that restarts, retimes or corrupts the byte shows up in the timing, readback or slave data checks.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
  localparam int BUS_W   = 32;
  localparam int PRESC_W = 3;

  // word indices (byte offset / 4)
  localparam int IDX_STAT = 0;
  localparam int IDX_CFG  = 4;
  localparam int IDX_CTL  = 5;
  localparam int IDX_DATA = 8;

  localparam int CFG_TXF_BIT = 4;
  localparam int CFG_RXF_BIT = 5;
  localparam int CFG_POL_BIT = 6;
  localparam int CFG_MSB_BIT = 8;

  localparam int CTL_CS_BIT = 0;
  localparam int CTL_RD_BIT = 1;
  localparam int CTL_WR_BIT = 2;

  typedef struct packed {
    logic               msb_first;
    logic               pol;
    logic               rx_fall;
    logic               tx_fall;
    logic [PRESC_W-1:0] presc;
  } cfg_t;

  function automatic logic [BUS_W-1:0] cfg_pack(input cfg_t c);
    logic [BUS_W-1:0] w;
    w                = '0;
    w[PRESC_W-1:0]   = c.presc;
    w[CFG_TXF_BIT]   = c.tx_fall;
    w[CFG_RXF_BIT]   = c.rx_fall;
    w[CFG_POL_BIT]   = c.pol;
    w[CFG_MSB_BIT]   = c.msb_first;
    return w;
  endfunction

  function automatic cfg_t cfg_unpack(input logic [BUS_W-1:0] w);
    cfg_t c;
    c.presc     = w[PRESC_W-1:0];
    c.tx_fall   = w[CFG_TXF_BIT];
    c.rx_fall   = w[CFG_RXF_BIT];
    c.pol       = w[CFG_POL_BIT];
    c.msb_first = w[CFG_MSB_BIT];
    return c;
  endfunction
endpackage

// File: rtl/spibm_regs.sv
module spibm_regs
  import spibm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              rx_load,
  input  logic [BITS-1:0]   rx_byte,
  output cfg_t              cfg,
  output logic              cs_lvl,
  output logic [BITS-1:0]   data_byte,
  output logic              start,
  output logic              start_rd,
  output logic              op_rd
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr, hit_cfg, hit_ctl, hit_data;
  logic             wr_cfg, wr_ctl, wr_data;
  cfg_t             cfg_q, cfg_d;
  logic             cs_q, cs_d;
  logic [BITS-1:0]  data_q, data_d;
  logic             op_rd_q, op_rd_d;
  logic             unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_comb begin
    idx      = bus_addr[ADDR_W-1:2];
    wr       = bus_en & bus_we;
    hit_cfg  = (idx == IDX_W'(IDX_CFG));
    hit_ctl  = (idx == IDX_W'(IDX_CTL));
    hit_data = (idx == IDX_W'(IDX_DATA));
    wr_cfg   = wr & hit_cfg & ~busy;
    wr_data  = wr & hit_data & ~busy;
    wr_ctl   = wr & hit_ctl;
    start    = wr_ctl & ~busy & (bus_wdata[CTL_WR_BIT] | bus_wdata[CTL_RD_BIT]);
    start_rd = ~bus_wdata[CTL_WR_BIT] & bus_wdata[CTL_RD_BIT];
  end

  // next-state
  always_comb begin
    cfg_d   = cfg_q;
    cs_d    = cs_q;
    data_d  = data_q;
    op_rd_d = op_rd_q;
    if (wr_cfg)  cfg_d = cfg_unpack(bus_wdata);
    if (wr_ctl)  cs_d  = bus_wdata[CTL_CS_BIT];
    if (start)   op_rd_d = start_rd;
    if (rx_load)      data_d = rx_byte;
    else if (wr_data) data_d = bus_wdata[BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cs_q    <= 1'b1;
      data_q  <= '0;
      op_rd_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      cs_q    <= cs_d;
      data_q  <= data_d;
      op_rd_q <= op_rd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_W'(IDX_STAT): bus_rdata[0] = busy;
      IDX_W'(IDX_CFG):  bus_rdata = cfg_pack(cfg_q);
      IDX_W'(IDX_CTL):  bus_rdata[CTL_CS_BIT] = cs_q;
      IDX_W'(IDX_DATA): bus_rdata = BUS_W'(data_q);
      default:          bus_rdata = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign cs_lvl    = cs_q;
  assign data_byte = data_q;
  assign op_rd     = op_rd_q;
endmodule

// File: rtl/spibm_sckgen.sv
module spibm_sckgen
  import spibm_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int MAX_PRESC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PRESC_W-1:0] presc,
  output logic               busy,
  output logic               tog,
  output logic               edge_now,
  output logic               first_edge,
  output logic               last_edge
);
  localparam int EDGES  = 2 * BITS;
  localparam int ECNT_W = $clog2(EDGES);
  localparam int DIV_W  = (MAX_PRESC > 0) ? MAX_PRESC : 1;

  logic               busy_q, busy_d;
  logic               tog_q, tog_d;
  logic [ECNT_W-1:0]  ecnt_q, ecnt_d;
  logic [DIV_W-1:0]   div_q, div_d, half_m1;
  logic [PRESC_W-1:0] presc_eff;

  always_comb begin
    presc_eff  = (presc > PRESC_W'(MAX_PRESC)) ? PRESC_W'(MAX_PRESC) : presc;
    half_m1    = DIV_W'((1 << presc_eff) - 1);
    edge_now   = busy_q & (div_q == half_m1);
    first_edge = edge_now & (ecnt_q == '0);
    last_edge  = edge_now & (ecnt_q == ECNT_W'(EDGES - 1));
  end

  // next-state
  always_comb begin
    busy_d = busy_q;
    tog_d  = tog_q;
    ecnt_d = ecnt_q;
    div_d  = div_q;
    if (start) begin
      busy_d = 1'b1;
      tog_d  = 1'b0;
      ecnt_d = '0;
      div_d  = '0;
    end else if (busy_q) begin
      if (edge_now) begin
        div_d  = '0;
        tog_d  = ~tog_q;
        ecnt_d = ecnt_q + 1'b1;
        if (last_edge) busy_d = 1'b0;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      ecnt_q <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      tog_q  <= tog_d;
      ecnt_q <= ecnt_d;
      div_q  <= div_d;
    end
  end

  assign busy = busy_q;
  assign tog  = tog_q;
endmodule

// File: rtl/spibm_shift.sv
module spibm_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            msb_first,
  input  logic            tx_fall,
  input  logic            rx_fall,
  input  logic            pol,
  input  logic            tog,
  input  logic            edge_now,
  input  logic            first_edge,
  input  logic            last_edge,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  logic [BITS-1:0] tx_q, tx_d, rx_q, rx_d, rx_next;
  logic            sck_rise, tx_edge, rx_edge, tx_adv;

  always_comb begin
    // sck is currently low when pol ^ tog == 0, so this edge rises
    sck_rise = ~(pol ^ tog);
    tx_edge  = edge_now & (sck_rise ? ~tx_fall : tx_fall);
    rx_edge  = edge_now & (sck_rise ? ~rx_fall : rx_fall);
    tx_adv   = tx_edge & ~first_edge & ~last_edge;

    rx_next = rx_q;
    if (rx_edge) begin
      if (msb_first) rx_next = {rx_q[BITS-2:0], miso};
      else           rx_next = {miso, rx_q[BITS-1:1]};
    end
    rx_d = start ? '0 : rx_next;

    tx_d = tx_q;
    if (start) begin
      tx_d = tx_byte;
    end else if (tx_adv) begin
      if (msb_first) tx_d = {tx_q[BITS-2:0], 1'b0};
      else           tx_d = {1'b0, tx_q[BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = msb_first ? tx_q[BITS-1] : tx_q[0];
  assign rx_byte = rx_next;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spibm_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BITS        = 8,
  parameter int MAX_PRESC   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_o
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  cfg_t            cfg_q;
  logic            busy_w, tog_w, edge_w, first_w, last_w;
  logic            start_w, start_rd_w, op_rd_w, rx_load_w;
  logic [BITS-1:0] data_w, rx_byte_w;
  logic            cfg_pol_w;
  logic [31:0]     cfg_word_w;

  spibm_regs #(.ADDR_W(ADDR_W), .BITS(BITS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .rx_load(rx_load_w), .rx_byte(rx_byte_w),
    .cfg(cfg_q), .cs_lvl(cs_o), .data_byte(data_w),
    .start(start_w), .start_rd(start_rd_w), .op_rd(op_rd_w)
  );

  spibm_sckgen #(.BITS(BITS), .MAX_PRESC(MAX_PRESC)) u_sck (
    .clk(clk), .rst_n(rst_sync_n), .start(start_w), .presc(cfg_q.presc),
    .busy(busy_w), .tog(tog_w), .edge_now(edge_w),
    .first_edge(first_w), .last_edge(last_w)
  );

  spibm_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .start(start_w), .tx_byte(data_w),
    .msb_first(cfg_q.msb_first), .tx_fall(cfg_q.tx_fall),
    .rx_fall(cfg_q.rx_fall), .pol(cfg_q.pol), .tog(tog_w),
    .edge_now(edge_w), .first_edge(first_w), .last_edge(last_w),
    .miso(miso_i), .mosi(mosi_o), .rx_byte(rx_byte_w)
  );

  assign rx_load_w  = last_w & op_rd_w;
  assign sck_o      = cfg_q.pol ^ tog_w;
  assign cfg_pol_w  = cfg_q.pol;
  assign cfg_word_w = cfg_pack(cfg_q);
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spibm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-3:0] idx,
  input logic [2:0]        wd,
  input logic              cs_o,
  input logic              sck_o,
  input logic              mosi_o,
  input logic              busy,
  input logic              pol,
  input logic [31:0]       cfg_word
);
  logic ctl_wr;
  assign ctl_wr = bus_en & bus_we & (idx == (ADDR_W-2)'(IDX_CTL));

  AST_CS_FOLLOWS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (cs_o == $past(wd[CTL_CS_BIT]))); // R10

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy && (wd[CTL_WR_BIT] || wd[CTL_RD_BIT])) |=> busy); // R3

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_o == pol)); // R4

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_word)); // R11

  AST_MOSI_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sck_o)) |-> $stable(mosi_o)); // R5
endmodule

bind spi_byte_master spi_byte_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_en(bus_en), .bus_we(bus_we),
  .idx(bus_addr[ADDR_W-1:2]), .wd(bus_wdata[2:0]), .cs_o(cs_o),
  .sck_o(sck_o), .mosi_o(mosi_o), .busy(busy_w), .pol(cfg_pol_w),
  .cfg_word(cfg_word_w)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_STAT = 6'h00, A_CFG = 6'h10, A_CTL = 6'h14,
                            A_DATA = 6'h20, A_RES0 = 6'h08, A_RES1 = 6'h3C;

  logic          clk, rst_n, bus_en, bus_we, miso_i;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          sck_o, mosi_o, cs_o;

  int errors = 0, total = 0, cyc = 0;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model: drives on the edges the master does not sample,
  // captures on the edges the master does not launch
  bit       in_x = 1'b0, sl_txf, sl_rxf;
  logic [7:0] sl_bits, sl_got;
  int       sl_k, sl_edges, sl_rxn;

  always @(sck_o) begin
    if (in_x) begin
      sl_edges = sl_edges + 1;
      if ((sck_o && sl_rxf) || (!sck_o && !sl_rxf)) begin
        if (sl_edges != 1 && sl_k < 7) begin
          sl_k   = sl_k + 1;
          miso_i = sl_bits[sl_k];
        end
      end
      if ((sck_o && sl_txf) || (!sck_o && !sl_txf)) begin
        sl_got = {sl_got[6:0], mosi_o};
        sl_rxn = sl_rxn + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // op: 2'b01 read, 2'b10 write, 2'b11 both start bits (acts as write)
  task automatic xfer(input int p, input bit pol, input bit txf, input bit rxf,
                      input bit msb, input logic [1:0] op, input logic [7:0] b,
                      input bit poke);
    logic [31:0] cfgv, rd;
    logic [7:0]  send;
    bit          is_rd;
    int          t0, n, half;
    is_rd = (op == 2'b01);
    half  = 1 << ((p > 6) ? 6 : p);
    cfgv  = 32'(p) | (32'(txf) << 4) | (32'(rxf) << 5) | (32'(pol) << 6) | (32'(msb) << 8);
    bus_write(A_CFG, cfgv);
    bus_read(A_CFG, rd);
    chk("R2 cfg readback", rd, cfgv);
    chk("R4 sck idle", {31'b0, sck_o}, {31'b0, pol});
    if (!is_rd) begin
      bus_write(A_DATA, 32'hA5A5_A500 | 32'(b));
      bus_read(A_DATA, rd);
      chk("R2 data low byte only", rd, 32'(b));
    end
    send = is_rd ? b : ~b;
    for (int i = 0; i < 8; i++) sl_bits[i] = msb ? send[7-i] : send[i];
    sl_k = 0; sl_edges = 0; sl_rxn = 0; sl_got = 8'h00;
    sl_txf = txf; sl_rxf = rxf;
    miso_i = sl_bits[0];
    in_x = 1'b1;
    bus_write(A_CTL, {29'b0, op, 1'b0});
    t0 = cyc;
    chk("R10 cs low", {31'b0, cs_o}, 32'h0);
    if (poke) begin
      bus_write(A_DATA, 32'hFF);
      bus_write(A_CFG, 32'h1FF);
      bus_write(A_CTL, 32'h7);
      chk("R10 cs high while busy", {31'b0, cs_o}, 32'h1);
    end
    bus_read(A_STAT, rd);
    while (rd[0] && (cyc - t0) < 5000) begin
      @(negedge clk);
      bus_read(A_STAT, rd);
    end
    n = cyc - t0;
    in_x = 1'b0;
    chk((p == 7) ? "R13 busy length at P=7" : "R3 busy length", 32'(n), 32'(16 * half));
    chk("R4 sck transitions", 32'(sl_edges), 32'd16);
    chk("R4 sck back to idle", {31'b0, sck_o}, {31'b0, pol});
    bus_read(A_DATA, rd);
    if (is_rd) begin
      chk("R9 R6 R7 received byte", rd, 32'(b));
    end else begin
      chk(op == 2'b11 ? "R12 both bits write" : "R8 data kept after write", rd, 32'(b));
      chk("R5 R7 slave saw byte", {24'b0, sl_got}, {24'b0, msb ? b : rev8(b)});
      chk("R5 slave sample count", 32'(sl_rxn), 32'd8);
    end
    if (poke) begin
      bus_read(A_CFG, rd);
      chk("R11 cfg unchanged", rd, cfgv);
    end
    bus_write(A_CTL, 32'h1);
    chk("R10 cs high", {31'b0, cs_o}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  b;
    int          k;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; miso_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(A_STAT, rd); chk("R1 status", rd, 32'h0);
    bus_read(A_CFG, rd);  chk("R1 cfg", rd, 32'h0);
    bus_read(A_CTL, rd);  chk("R1 ctl", rd, 32'h1);
    bus_read(A_DATA, rd); chk("R1 data", rd, 32'h0);
    chk("R1 cs_o", {31'b0, cs_o}, 32'h1);
    chk("R1 sck_o", {31'b0, sck_o}, 32'h0);

    // R2 field masks and reserved offsets
    bus_write(A_CFG, 32'hFFFF_FFFF);
    bus_read(A_CFG, rd);  chk("R2 cfg mask", rd, 32'h177);
    bus_write(A_CTL, 32'hFFFF_FFF9);
    bus_read(A_CTL, rd);  chk("R2 ctl mask", rd, 32'h1);
    bus_read(A_STAT, rd); chk("R2 no start from mask write", rd, 32'h0);
    bus_write(A_RES0, 32'hFFFF_FFFF);
    bus_write(A_RES1, 32'hFFFF_FFFF);
    bus_read(A_RES0, rd); chk("R2 reserved 0x08", rd, 32'h0);
    bus_read(A_RES1, rd); chk("R2 reserved 0x3C", rd, 32'h0);
    bus_read(A_CFG, rd);  chk("R2 cfg untouched by reserved", rd, 32'h177);
    bus_read(A_STAT, rd); chk("R2 status untouched", rd, 32'h0);
    bus_write(A_CTL, 32'h0);
    chk("R10 cs low idle", {31'b0, cs_o}, 32'h0);
    bus_write(A_CTL, 32'h1);

    // edge / polarity / order sweep at the two fastest rates
    k = 0;
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 8; m++)
        for (int o = 0; o < 2; o++)
          for (int d = 0; d < 2; d++) begin
            b = 8'h5A ^ 8'(k * 37);
            xfer(p, m[2], m[0], m[1], o[0], d[0] ? 2'b01 : 2'b10, b, 1'b0);
            k++;
          end

    // prescale sweep including the clamped code 7 (R13)
    for (int p = 0; p < 8; p++) begin
      xfer(p, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 8'hC1 ^ 8'(p), 1'b0);
      xfer(p, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 8'h3E ^ 8'(p * 9), 1'b0);
    end

    // R12 both start bits
    xfer(1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 8'h96, 1'b0);
    // R11 writes during busy are ignored, R10 cs still follows
    xfer(2, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 8'h3C, 1'b1);
    xfer(2, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 8'hB2, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule